// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block produces four active-low chip selects for external memory devices. Each chip select owns an address window measured in 64 KB pages, which is the top byte of a 24-bit address. The window is an inclusive range between a programmable lower page and a programmable upper page, and it is qualified by an enable bit. During every cycle the top address byte, the memory-request strobe and an internal-memory hit flag are captured in a register. The chip selects are then decoded combinationally from that captured state.

When several enabled windows cover the same page, the chip select with the lowest index wins. A hit reported by the separate internal-memory decoder takes precedence over all four external selects. When no memory request is in progress, every output is held high.

A small write port programs the windows. The port address carries the chip-select index in its upper bits and a field code in its two low bits. After reset, chip select 0 covers the entire map, so a system can boot from external memory without first programming the decoder.

Top module: `mem_cs_decoder`

## Requirements
- R1: After reset, with no register writes, every memory request asserts `cs_n[0]` low for any page 00h..FFh, and `cs_n[3:1]` stay high.
- R2: A window hits when its enable is 1 and lower ≤ page ≤ upper, compared unsigned and inclusive at both ends. The page one below the lower bound is a miss, and so is the page one above the upper bound.
- R3: A window whose lower bound equals its upper bound hits exactly that one page and misses the pages on either side.
- R4: A window whose lower bound is greater than its upper bound never hits, including at either bound value.
- R5: When several windows hit, only the lowest-index chip select among them goes low.
- R6: When `int_mem_hit` is 1 on a request, all of `cs_n` are high, even if a window covers the page.
- R7: A chip select whose enable is 0 never goes low. After reset the enables are 1 for chip select 0 and 0 for the others, and the bounds of chip selects 1..3 are 00h.
- R8: When `mem_req` is 0, all of `cs_n` are high.
- R9: At most one bit of `cs_n` is low in any cycle.
- R10: `cs_n` reflects the `mem_req`, `mem_page` and `int_mem_hit` values sampled at the previous rising clock edge. Input changes between edges do not affect the outputs.
- R11: A write with `cfg_we`=1 updates one field. `cfg_addr[3:2]` selects the chip-select index. `cfg_addr[1:0]` selects the field: 0 = lower bound, 1 = upper bound, 2 = enable (taken from `cfg_wdata[0]`), 3 = no field. A write to code 3 changes nothing, and an enable write uses only bit 0 of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_req | input | 1 | Memory-cycle strobe |
| mem_page | input | 8 | Address bits 23:16 (64 KB page number) |
| int_mem_hit | input | 1 | Internal-memory decoder reports a hit |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address: {index[1:0], field[1:0]} |
| cfg_wdata | input | 8 | Register write data |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench probes each window one page below, at, and one page above both bounds. An off-by-one or signed compare would therefore show up as a select at a neighbouring page, or as a missing select. Inverted and single-page windows are tested separately, because a compare that ignores ordering would fire on inverted windows. Overlapping windows check that only the lowest index is driven low; a wrong priority would drive two selects low at once or pick the wrong one. Further cases confirm the following:
- an internal hit and an idle bus both force all selects high;
- a reserved field code leaves the map untouched;
- inputs changed between edges do not reach the outputs before the next edge.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Field codes carried in the low two bits of the configuration address.
  typedef enum logic [1:0] {
    FLD_LOWER  = 2'd0,
    FLD_UPPER  = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_NONE   = 2'd3
  } mcs_field_e;

  localparam int unsigned FIELD_W = 2;

endpackage

// File: rtl/mcs_win_regs.sv
module mcs_win_regs
  import mcs_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CADR_W = IDX_W + FIELD_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CADR_W-1:0]                cfg_addr,
  input  logic [PAGE_W-1:0]                cfg_wdata,
  output logic [NUM_CS-1:0][PAGE_W-1:0]    lo_bound,
  output logic [NUM_CS-1:0][PAGE_W-1:0]    hi_bound,
  output logic [NUM_CS-1:0]                win_en
);

  // Reset map: window 0 spans every page and is enabled, the rest are zero.
  localparam logic [NUM_CS-1:0][PAGE_W-1:0] RST_LO = '0;
  localparam logic [NUM_CS-1:0][PAGE_W-1:0] RST_HI =
    {{((NUM_CS-1)*PAGE_W){1'b0}}, {PAGE_W{1'b1}}};
  localparam logic [NUM_CS-1:0] RST_EN = NUM_CS'(1);

  logic [NUM_CS-1:0][PAGE_W-1:0] lo_q, lo_d;
  logic [NUM_CS-1:0][PAGE_W-1:0] hi_q, hi_d;
  logic [NUM_CS-1:0]             en_q, en_d;
  logic [IDX_W-1:0]              wr_idx;
  mcs_field_e                    wr_fld;
  logic                          idx_ok;

  assign wr_idx = cfg_addr[CADR_W-1:FIELD_W];
  assign wr_fld = mcs_field_e'(cfg_addr[FIELD_W-1:0]);
  assign idx_ok = (32'(wr_idx) < NUM_CS);

  // Next-state logic.
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    en_d = en_q;
    if (cfg_we && idx_ok) begin
      case (wr_fld)
        FLD_LOWER:  lo_d[wr_idx] = cfg_wdata;
        FLD_UPPER:  hi_d[wr_idx] = cfg_wdata;
        FLD_ENABLE: en_d[wr_idx] = cfg_wdata[0];
        default:    ;
      endcase
    end
  end

  // State registers with an explicit load enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= RST_LO;
      hi_q <= RST_HI;
      en_q <= RST_EN;
    end else if (cfg_we) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      en_q <= en_d;
    end
  end

  assign lo_bound = lo_q;
  assign hi_bound = hi_q;
  assign win_en   = en_q;

endmodule

// File: rtl/mcs_win_cmp.sv
module mcs_win_cmp #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] lo,
  input  logic [PAGE_W-1:0] hi,
  input  logic              en,
  output logic              hit
);

  logic ge_lo;
  logic le_hi;

  // Unsigned inclusive compare; an inverted window can never satisfy both.
  assign ge_lo = (page >= lo);
  assign le_hi = (page <= hi);
  assign hit   = en && ge_lo && le_hi;

endmodule

// File: rtl/mcs_prio_sel.sv
module mcs_prio_sel #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              req,
  input  logic              int_hit,
  input  logic [NUM_CS-1:0] hit,
  output logic [NUM_CS-1:0] cs_n
);

  logic [NUM_CS-1:0] grant;
  logic              taken;

  // Fixed priority: the lowest index that hits is granted.
  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // Qualify with the strobe; an internal hit blocks every external select.
  always_comb begin
    if (req && !int_hit) cs_n = ~grant;
    else                 cs_n = '1;
  end

endmodule

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder
  import mcs_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CADR_W = IDX_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic [PAGE_W-1:0] mem_page,
  input  logic              int_mem_hit,
  input  logic              cfg_we,
  input  logic [CADR_W-1:0] cfg_addr,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [NUM_CS-1:0] cs_n
);

  // Reset: asserted asynchronously, removed in step with the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address-phase capture.
  logic              req_q, req_d;
  logic              ih_q,  ih_d;
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    req_d  = mem_req;
    ih_d   = int_mem_hit;
    page_d = mem_page;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q  <= 1'b0;
      ih_q   <= 1'b0;
      page_q <= '0;
    end else begin
      req_q  <= req_d;
      ih_q   <= ih_d;
      page_q <= page_d;
    end
  end

  // Window registers.
  logic [NUM_CS-1:0][PAGE_W-1:0] lo_bound;
  logic [NUM_CS-1:0][PAGE_W-1:0] hi_bound;
  logic [NUM_CS-1:0]             win_en;
  logic [NUM_CS-1:0]             win_hit;

  mcs_win_regs #(
    .NUM_CS (NUM_CS),
    .PAGE_W (PAGE_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lo_bound  (lo_bound),
    .hi_bound  (hi_bound),
    .win_en    (win_en)
  );

  // One comparator per chip select.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    mcs_win_cmp #(
      .PAGE_W (PAGE_W)
    ) i_cmp (
      .page (page_q),
      .lo   (lo_bound[g]),
      .hi   (hi_bound[g]),
      .en   (win_en[g]),
      .hit  (win_hit[g])
    );
  end

  mcs_prio_sel #(
    .NUM_CS (NUM_CS)
  ) i_prio (
    .req     (req_q),
    .int_hit (ih_q),
    .hit     (win_hit),
    .cs_n    (cs_n)
  );

endmodule

// File: rtl/mem_cs_decoder_chk.sv
module mem_cs_decoder_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              int_hit,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] win_hit,
  input logic [NUM_CS-1:0] win_en
);

  // R9: never more than one select low.
  p_single_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8: an idle bus leaves every select high on the next cycle.
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> (&cs_n));

  // R6: an internal hit blocks every external select.
  p_int_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |=> (&cs_n));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_chk
    localparam logic [NUM_CS-1:0] LOWER = NUM_CS'((1 << i) - 1);

    // R7: a disabled window never drives its select.
    p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> win_en[i]);

    // R5: a low select must hit with no lower-index window hitting.
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> (win_hit[i] && ((win_hit & LOWER) == '0)));
  end

endmodule

bind mem_cs_decoder mem_cs_decoder_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req),
  .int_hit (int_mem_hit),
  .cs_n    (cs_n),
  .win_hit (win_hit),
  .win_en  (win_en)
);

// File: tb/test_mem_cs_decoder.sv
module test_mem_cs_decoder;

  logic       clk;
  logic       rst_n;
  logic       mem_req;
  logic [7:0] mem_page;
  logic       int_mem_hit;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [3:0] cs_n;

  int nvec;
  int nerr;

  // Bench-side view of the programmed windows.
  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic       m_en [4];

  mem_cs_decoder i_mem_cs_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_page    (mem_page),
    .int_mem_hit (int_mem_hit),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cs_n        (cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] expect_cs(input logic req, input logic [7:0] pg,
                                           input logic ih);
    logic [3:0] r;
    r = 4'hF;
    if (req && !ih) begin
      for (int i = 3; i >= 0; i--)
        if (m_en[i] && pg >= m_lo[i] && pg <= m_hi[i]) r = ~(4'b0001 << i);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    nvec++;
    if (cs_n !== exp) begin
      nerr++;
      $display("FAIL %s: cs_n got %b expected %b", tag, cs_n, exp);
    end
  endtask

  // Drive one bus cycle at a falling edge, check after the next rising edge.
  task automatic apply(input string tag, input logic req, input logic [7:0] pg,
                       input logic ih);
    @(negedge clk);
    mem_req = req; mem_page = pg; int_mem_hit = ih;
    @(negedge clk);
    check(tag, expect_cs(req, pg, ih));
  endtask

  // field: 0 lower, 1 upper, 2 enable, 3 none
  task automatic wr(input int idx, input int fld, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'(idx), 2'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (fld)
      0: m_lo[idx] = d;
      1: m_hi[idx] = d;
      2: m_en[idx] = d[0];
      default: ;
    endcase
  endtask

  task automatic t_reset_defaults;
    check("R8 idle after reset", 4'hF);
    apply("R1 page 00", 1'b1, 8'h00, 1'b0);
    apply("R1 page 7F", 1'b1, 8'h7F, 1'b0);
    apply("R1 page FF", 1'b1, 8'hFF, 1'b0);
    // R7: disable window 0, enable window 1 with its reset bounds 00..00.
    wr(0, 2, 8'h00);
    wr(1, 2, 8'h01);
    apply("R7 reset bounds cs1 page 00", 1'b1, 8'h00, 1'b0);
    apply("R7 reset bounds cs1 page 01", 1'b1, 8'h01, 1'b0);
    wr(2, 2, 8'h00);
    apply("R7 cs0 disabled page 80", 1'b1, 8'h80, 1'b0);
    wr(1, 2, 8'h00);
  endtask

  task automatic t_ranges;
    wr(1, 0, 8'h10); wr(1, 1, 8'h1F); wr(1, 2, 8'h01);
    wr(2, 0, 8'h20); wr(2, 1, 8'h2F); wr(2, 2, 8'h01);
    wr(3, 0, 8'h30); wr(3, 1, 8'h30); wr(3, 2, 8'h01);
    apply("R2 below cs1", 1'b1, 8'h0F, 1'b0);
    apply("R2 cs1 lower", 1'b1, 8'h10, 1'b0);
    apply("R2 cs1 upper", 1'b1, 8'h1F, 1'b0);
    apply("R2 cs2 lower", 1'b1, 8'h20, 1'b0);
    apply("R2 cs2 upper", 1'b1, 8'h2F, 1'b0);
    apply("R3 single page", 1'b1, 8'h30, 1'b0);
    apply("R3 above single", 1'b1, 8'h31, 1'b0);
    apply("R2 high page unsigned", 1'b1, 8'hF0, 1'b0);
  endtask

  task automatic t_inverted;
    wr(1, 0, 8'h50); wr(1, 1, 8'h40);
    apply("R4 inverted at upper", 1'b1, 8'h40, 1'b0);
    apply("R4 inverted middle", 1'b1, 8'h45, 1'b0);
    apply("R4 inverted at lower", 1'b1, 8'h50, 1'b0);
  endtask

  task automatic t_priority;
    wr(0, 0, 8'h00); wr(0, 1, 8'h1F); wr(0, 2, 8'h01);
    wr(1, 0, 8'h10); wr(1, 1, 8'h3F);
    wr(2, 0, 8'h00); wr(2, 1, 8'hFF);
    apply("R5 cs0 over cs1 cs2", 1'b1, 8'h15, 1'b0);
    apply("R5 cs1 over cs2 cs3", 1'b1, 8'h30, 1'b0);
    apply("R5 cs2 only", 1'b1, 8'h80, 1'b0);
  endtask

  task automatic t_internal_and_idle;
    apply("R6 internal hit", 1'b1, 8'h15, 1'b1);
    apply("R6 released", 1'b1, 8'h15, 1'b0);
    apply("R8 no request", 1'b0, 8'h15, 1'b0);
  endtask

  task automatic t_timing;
    apply("R10 setup", 1'b1, 8'h80, 1'b0);
    @(negedge clk);
    mem_page = 8'h15;
    #5;
    check("R10 held before edge", 4'b1011);
    @(negedge clk);
    check("R10 after edge", 4'b1110);
  endtask

  task automatic t_field_codes;
    wr(0, 3, 8'h00);
    apply("R11 code 3 no effect", 1'b1, 8'h05, 1'b0);
    wr(0, 2, 8'hFE);
    apply("R11 enable uses bit0", 1'b1, 8'h05, 1'b0);
  endtask

  initial begin
    nvec = 0; nerr = 0;
    rst_n = 1'b0; mem_req = 1'b0; mem_page = '0; int_mem_hit = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_lo = '{8'h00, 8'h00, 8'h00, 8'h00};
    m_hi = '{8'hFF, 8'h00, 8'h00, 8'h00};
    m_en = '{1'b1, 1'b0, 1'b0, 1'b0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_defaults();
    t_ranges();
    t_inverted();
    t_priority();
    t_internal_and_idle();
    t_timing();
    t_field_codes();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule